// File: doc/BRIEF.md
# Flag-Aware Register Rename Table

This block is the rename stage of a small out-of-order integer core. Each integer micro-op arrives with two architectural source indices, an optional architectural destination, a mask of the flag groups it reads and a mask of the flag groups it writes. The stage turns the sources into physical register tags. It hands out at most one new physical register per micro-op. It records that register as the newest home of the destination and of every flag group the micro-op writes. Every physical register has room for a 6-bit flag field beside its integer value, so a result and its flags share one register.

The flags are split into two groups. The carry flag is one group, and the remaining five flags form the other. Each group has its own speculative pointer, so an increment that keeps the old carry needs no merge micro-op. A consumer that reads both groups gets two tags, which may name different registers.

A second, committed copy of all pointers advances as micro-ops retire. A register goes back to the free list only once no committed integer or flag pointer names it. A flush copies the committed state back into the speculative tables in one cycle and rebuilds the free list.

Top module: `flag_rename_table`

## Requirements
- R1: After reset, architectural register i maps to physical register i, both flag-group pointers name physical register ARCH_N (8 by default), and the free list holds physical registers ARCH_N+1 to PHYS_N-1.
- R2: A micro-op that writes a destination, a flag group, or both takes exactly one physical register. In the next cycle the destination entry and every written group pointer name that register.
- R3: While the free list is not empty, renNewPhys shows the lowest-numbered free register, and that register is the one taken.
- R4: The flag-write mask has bit 0 for the carry group and bit 1 for the group of the other five flags. Only the pointers of the groups whose bits are set move, and the other pointer keeps its value.
- R5: renPhysA and renPhysB give the current speculative mapping, including all earlier renames. renCarryTag and renOtherTag give the group pointers. renFlagTagVld equals the flag-read mask while renValid is high and is zero otherwise.
- R6: When a micro-op needs a register and none is free, renStall is high, renAlloc is low, and no pointer and no free-list bit changes. A micro-op that writes no destination and no flags never stalls.
- R7: A commit writes cmtPhys into the committed destination entry when cmtDstWr is set, and into each committed group pointer selected by cmtFlagWr (same bit order as R4).
- R8: On commit, a register that was named by the old committed state returns to the free list only if no committed integer or flag pointer still names it.
- R9: In a flush cycle no rename takes effect and renAlloc is low. In the next cycle every speculative pointer equals its committed copy, and the free list holds exactly the registers that no committed pointer names.
- R10: A register named by any committed pointer is never in the free list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | A micro-op is presented for renaming |
| renSrcA | input | AW | First architectural source |
| renSrcB | input | AW | Second architectural source |
| renDst | input | AW | Architectural destination |
| renDstWr | input | 1 | The micro-op writes renDst |
| renFlagRd | input | 2 | Flag groups read (bit 0 carry, bit 1 other) |
| renFlagWr | input | 2 | Flag groups written (bit 0 carry, bit 1 other) |
| renPhysA | output | PW | Physical tag for renSrcA |
| renPhysB | output | PW | Physical tag for renSrcB |
| renCarryTag | output | PW | Register holding the newest carry flag |
| renOtherTag | output | PW | Register holding the newest other five flags |
| renFlagTagVld | output | 2 | Which flag tags the micro-op consumes |
| renNewPhys | output | PW | Lowest free register, taken when renAlloc is high |
| renAlloc | output | 1 | A register is taken this cycle |
| renStall | output | 1 | The micro-op must be held: no register free |
| cmtValid | input | 1 | A micro-op retires |
| cmtDst | input | AW | Architectural destination of the retiring micro-op |
| cmtDstWr | input | 1 | The retiring micro-op wrote a destination |
| cmtFlagWr | input | 2 | Flag groups written by the retiring micro-op |
| cmtPhys | input | PW | Register allocated to the retiring micro-op |
| flush | input | 1 | Discard all speculative state |

## Verification
The bound checker watches several rules on every cycle. A committed register is never free. At most one register leaves the free list per cycle, and a taken register is free before it is taken and gone after. A stalled cycle leaves the speculative tables unchanged. A combined result-and-flags write points all three entries at one register, and a flush is followed by equal speculative and committed tables. Other behaviour shows only in the bench's scenarios: which register is chosen, which tags a consumer sees after a run of partial flag writes, and whether a register kept alive only by the committed carry pointer stays out of the free list until a later commit releases it.

// File: rtl/frt_pkg.sv
`timescale 1ns/1ps
package frt_pkg;
  localparam int FLAG_BITS = 6;   // width of the flag field beside each physical register
  localparam int GRP_N     = 2;
  localparam int GRP_CARRY = 0;
  localparam int GRP_OTHER = 1;

  typedef struct packed {
    logic alloc;
    logic commit;
    logic flush;
  } frtStrobe_t;
endpackage

// File: rtl/frt_ctrl.sv
`timescale 1ns/1ps
module frt_ctrl
  import frt_pkg::*;
(
  input  logic             renValid,
  input  logic             renDstWr,
  input  logic [GRP_N-1:0] renFlagWr,
  input  logic             freeAny,
  input  logic             cmtValid,
  input  logic             flush,
  output frtStrobe_t       strb,
  output logic             stall
);
  logic needReg;

  always_comb begin
    needReg     = renValid && (renDstWr || (|renFlagWr));
    strb.flush  = flush;
    strb.commit = cmtValid;
    strb.alloc  = needReg && freeAny && !flush;
    stall       = needReg && !freeAny && !flush;
  end
endmodule

// File: rtl/frt_freelist.sv
`timescale 1ns/1ps
module frt_freelist
  import frt_pkg::*;
#(
  parameter int ARCH_N = 8,
  parameter int PHYS_N = 16,
  localparam int PW = $clog2(PHYS_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  frtStrobe_t        strb,
  input  logic [PHYS_N-1:0] releaseMask,
  input  logic [PHYS_N-1:0] rebuildMask,
  output logic [PHYS_N-1:0] freeMask,
  output logic              freeAny,
  output logic [PW-1:0]     headIdx
);
  function automatic logic [PHYS_N-1:0] initFree();
    logic [PHYS_N-1:0] m;
    for (int i = 0; i < PHYS_N; i++) m[i] = (i > ARCH_N);
    return m;
  endfunction

  localparam logic [PHYS_N-1:0] RESET_FREE = initFree();

  logic [PHYS_N-1:0] popMask;

  always_comb begin
    headIdx = '0;
    for (int i = PHYS_N - 1; i >= 0; i--) begin
      if (freeMask[i]) headIdx = PW'(i);
    end
    freeAny = |freeMask;
    popMask = '0;
    if (strb.alloc) popMask[headIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeMask <= RESET_FREE;
    end else if (strb.flush) begin
      freeMask <= rebuildMask;
    end else begin
      freeMask <= (freeMask & ~popMask) | releaseMask;
    end
  end
endmodule

// File: rtl/frt_datapath.sv
`timescale 1ns/1ps
module frt_datapath
  import frt_pkg::*;
#(
  parameter int ARCH_N = 8,
  parameter int PHYS_N = 16,
  localparam int AW = $clog2(ARCH_N),
  localparam int PW = $clog2(PHYS_N)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  frtStrobe_t                   strb,
  input  logic [AW-1:0]                renSrcA,
  input  logic [AW-1:0]                renSrcB,
  input  logic [AW-1:0]                renDst,
  input  logic                         renDstWr,
  input  logic [GRP_N-1:0]             renFlagWr,
  input  logic [PW-1:0]                headIdx,
  input  logic [AW-1:0]                cmtDst,
  input  logic                         cmtDstWr,
  input  logic [GRP_N-1:0]             cmtFlagWr,
  input  logic [PW-1:0]                cmtPhys,
  output logic [PW-1:0]                physA,
  output logic [PW-1:0]                physB,
  output logic [PW-1:0]                carryTag,
  output logic [PW-1:0]                otherTag,
  output logic [PHYS_N-1:0]            releaseMask,
  output logic [PHYS_N-1:0]            rebuildMask,
  output logic [PHYS_N-1:0]            cmtUse,
  output logic [ARCH_N-1:0][PW-1:0]    specInt,
  output logic [GRP_N-1:0][PW-1:0]     specFlg,
  output logic [ARCH_N-1:0][PW-1:0]    cmtInt,
  output logic [GRP_N-1:0][PW-1:0]     cmtFlg
);
  logic [ARCH_N-1:0][PW-1:0] cmtIntNext;
  logic [GRP_N-1:0][PW-1:0]  cmtFlgNext;
  logic [PHYS_N-1:0]         useNext;

  // source lookup
  assign physA    = specInt[renSrcA];
  assign physB    = specInt[renSrcB];
  assign carryTag = specFlg[GRP_CARRY];
  assign otherTag = specFlg[GRP_OTHER];

  // committed state after this cycle's retirement
  always_comb begin
    cmtIntNext = cmtInt;
    cmtFlgNext = cmtFlg;
    if (strb.commit) begin
      if (cmtDstWr) cmtIntNext[cmtDst] = cmtPhys;
      for (int g = 0; g < GRP_N; g++) begin
        if (cmtFlagWr[g]) cmtFlgNext[g] = cmtPhys;
      end
    end
  end

  // which registers the committed pointers name, now and after commit
  always_comb begin
    cmtUse  = '0;
    useNext = '0;
    for (int i = 0; i < ARCH_N; i++) begin
      cmtUse[cmtInt[i]]      = 1'b1;
      useNext[cmtIntNext[i]] = 1'b1;
    end
    for (int g = 0; g < GRP_N; g++) begin
      cmtUse[cmtFlg[g]]      = 1'b1;
      useNext[cmtFlgNext[g]] = 1'b1;
    end
    releaseMask = strb.commit ? (cmtUse & ~useNext) : '0;
    rebuildMask = ~useNext;
  end

  // speculative and committed tables
  generate
    for (genvar a = 0; a < ARCH_N; a++) begin : g_int
      always_ff @(posedge clk) begin
        if (!rstN) begin
          specInt[a] <= PW'(a);
          cmtInt[a]  <= PW'(a);
        end else begin
          cmtInt[a] <= cmtIntNext[a];
          if (strb.flush)
            specInt[a] <= cmtIntNext[a];
          else if (strb.alloc && renDstWr && (renDst == AW'(a)))
            specInt[a] <= headIdx;
        end
      end
    end
    for (genvar g = 0; g < GRP_N; g++) begin : g_flg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          specFlg[g] <= PW'(ARCH_N);
          cmtFlg[g]  <= PW'(ARCH_N);
        end else begin
          cmtFlg[g] <= cmtFlgNext[g];
          if (strb.flush)
            specFlg[g] <= cmtFlgNext[g];
          else if (strb.alloc && renFlagWr[g])
            specFlg[g] <= headIdx;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/flag_rename_table.sv
`timescale 1ns/1ps
module flag_rename_table
  import frt_pkg::*;
#(
  parameter int ARCH_N = 8,
  parameter int PHYS_N = 16,
  localparam int AW = $clog2(ARCH_N),
  localparam int PW = $clog2(PHYS_N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             renValid,
  input  logic [AW-1:0]    renSrcA,
  input  logic [AW-1:0]    renSrcB,
  input  logic [AW-1:0]    renDst,
  input  logic             renDstWr,
  input  logic [GRP_N-1:0] renFlagRd,
  input  logic [GRP_N-1:0] renFlagWr,
  output logic [PW-1:0]    renPhysA,
  output logic [PW-1:0]    renPhysB,
  output logic [PW-1:0]    renCarryTag,
  output logic [PW-1:0]    renOtherTag,
  output logic [GRP_N-1:0] renFlagTagVld,
  output logic [PW-1:0]    renNewPhys,
  output logic             renAlloc,
  output logic             renStall,
  input  logic             cmtValid,
  input  logic [AW-1:0]    cmtDst,
  input  logic             cmtDstWr,
  input  logic [GRP_N-1:0] cmtFlagWr,
  input  logic [PW-1:0]    cmtPhys,
  input  logic             flush
);
  frtStrobe_t                strb;
  logic                      freeAny;
  logic [PW-1:0]             headIdx;
  logic [PHYS_N-1:0]         freeMask;
  logic [PHYS_N-1:0]         releaseMask;
  logic [PHYS_N-1:0]         rebuildMask;
  logic [PHYS_N-1:0]         cmtUse;
  logic [ARCH_N-1:0][PW-1:0] specInt;
  logic [GRP_N-1:0][PW-1:0]  specFlg;
  logic [ARCH_N-1:0][PW-1:0] cmtInt;
  logic [GRP_N-1:0][PW-1:0]  cmtFlg;

  frt_ctrl ctrl_i (
    .renValid (renValid),
    .renDstWr (renDstWr),
    .renFlagWr(renFlagWr),
    .freeAny  (freeAny),
    .cmtValid (cmtValid),
    .flush    (flush),
    .strb     (strb),
    .stall    (renStall)
  );

  frt_freelist #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N)) free_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .releaseMask(releaseMask),
    .rebuildMask(rebuildMask),
    .freeMask   (freeMask),
    .freeAny    (freeAny),
    .headIdx    (headIdx)
  );

  frt_datapath #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .renSrcA    (renSrcA),
    .renSrcB    (renSrcB),
    .renDst     (renDst),
    .renDstWr   (renDstWr),
    .renFlagWr  (renFlagWr),
    .headIdx    (headIdx),
    .cmtDst     (cmtDst),
    .cmtDstWr   (cmtDstWr),
    .cmtFlagWr  (cmtFlagWr),
    .cmtPhys    (cmtPhys),
    .physA      (renPhysA),
    .physB      (renPhysB),
    .carryTag   (renCarryTag),
    .otherTag   (renOtherTag),
    .releaseMask(releaseMask),
    .rebuildMask(rebuildMask),
    .cmtUse     (cmtUse),
    .specInt    (specInt),
    .specFlg    (specFlg),
    .cmtInt     (cmtInt),
    .cmtFlg     (cmtFlg)
  );

  assign renFlagTagVld = renValid ? renFlagRd : '0;
  assign renNewPhys    = headIdx;
  assign renAlloc      = strb.alloc;
endmodule

// File: rtl/frt_chk.sv
`timescale 1ns/1ps
module frt_chk
  import frt_pkg::*;
#(
  parameter int ARCH_N = 8,
  parameter int PHYS_N = 16,
  localparam int AW = $clog2(ARCH_N),
  localparam int PW = $clog2(PHYS_N)
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [AW-1:0]             renDst,
  input logic                      renDstWr,
  input logic [GRP_N-1:0]          renFlagWr,
  input logic                      renAlloc,
  input logic                      renStall,
  input logic [PW-1:0]             renNewPhys,
  input logic                      flush,
  input logic [PHYS_N-1:0]         freeMask,
  input logic [PHYS_N-1:0]         cmtUse,
  input logic [ARCH_N-1:0][PW-1:0] specInt,
  input logic [GRP_N-1:0][PW-1:0]  specFlg,
  input logic [ARCH_N-1:0][PW-1:0] cmtInt,
  input logic [GRP_N-1:0][PW-1:0]  cmtFlg
);
  // R10
  cmt_not_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmtUse & freeMask) == '0);

  // R3
  take_from_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    renAlloc |-> freeMask[renNewPhys]);

  // R2
  taken_leaves_chk: assert property (@(posedge clk) disable iff (!rstN)
    renAlloc |=> !freeMask[$past(renNewPhys)]);

  // R2
  one_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flush |=> $countones($past(freeMask) & ~freeMask) <= 1);

  // R2
  shared_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (renAlloc && renDstWr && (renFlagWr == 2'b11)) |=>
      (specInt[$past(renDst)] == specFlg[GRP_CARRY]) &&
      (specFlg[GRP_CARRY] == specFlg[GRP_OTHER]));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    renStall |=> $stable(specInt) && $stable(specFlg));

  // R9
  flush_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (specInt == cmtInt) && (specFlg == cmtFlg));
endmodule

bind flag_rename_table frt_chk #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .renDst    (renDst),
  .renDstWr  (renDstWr),
  .renFlagWr (renFlagWr),
  .renAlloc  (renAlloc),
  .renStall  (renStall),
  .renNewPhys(renNewPhys),
  .flush     (flush),
  .freeMask  (freeMask),
  .cmtUse    (cmtUse),
  .specInt   (specInt),
  .specFlg   (specFlg),
  .cmtInt    (cmtInt),
  .cmtFlg    (cmtFlg)
);

// File: tb/flag_rename_table_tb_top.sv
`timescale 1ns/1ps
module flag_rename_table_tb_top;
  localparam int ARCH_N = 8;
  localparam int PHYS_N = 16;
  localparam int AW = 3;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic          renValid, renDstWr, cmtValid, cmtDstWr, flush;
  logic [AW-1:0] renSrcA, renSrcB, renDst, cmtDst;
  logic [1:0]    renFlagRd, renFlagWr, cmtFlagWr, renFlagTagVld;
  logic [PW-1:0] renPhysA, renPhysB, renCarryTag, renOtherTag, renNewPhys, cmtPhys;
  logic          renAlloc, renStall;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  flag_rename_table #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N)) dut_i (.*);

  typedef struct packed {
    logic          v;
    logic [AW-1:0] a, b, d;
    logic          dw;
    logic [1:0]    frd, fwr;
    logic [PW-1:0] eA, eB, eC, eO, eN;
    logic          eAl;
  } vec_t;

  // hand-derived from R1..R5: lowest free register first, per-group flag pointers
  localparam vec_t VEC [0:6] = '{
    '{1'b1, 3'd2, 3'd3, 3'd1, 1'b1, 2'b00, 2'b11, 4'd2,  4'd3,  4'd8,  4'd8,  4'd9,  1'b1},
    '{1'b1, 3'd1, 3'd0, 3'd1, 1'b1, 2'b00, 2'b10, 4'd9,  4'd0,  4'd9,  4'd9,  4'd10, 1'b1},
    '{1'b1, 3'd1, 3'd5, 3'd4, 1'b1, 2'b01, 2'b11, 4'd10, 4'd5,  4'd9,  4'd10, 4'd11, 1'b1},
    '{1'b1, 3'd4, 3'd1, 3'd0, 1'b0, 2'b00, 2'b11, 4'd11, 4'd10, 4'd11, 4'd11, 4'd12, 1'b1},
    '{1'b1, 3'd7, 3'd0, 3'd6, 1'b1, 2'b00, 2'b00, 4'd7,  4'd0,  4'd12, 4'd12, 4'd13, 1'b1},
    '{1'b0, 3'd6, 3'd1, 3'd0, 1'b0, 2'b00, 2'b00, 4'd13, 4'd10, 4'd12, 4'd12, 4'd14, 1'b0},
    '{1'b1, 3'd0, 3'd0, 3'd0, 1'b0, 2'b11, 2'b00, 4'd0,  4'd0,  4'd12, 4'd12, 4'd14, 1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ren(input logic v, input int a, input int b, input int d,
                     input logic dw, input logic [1:0] frd, input logic [1:0] fwr);
    renValid = v; renSrcA = AW'(a); renSrcB = AW'(b); renDst = AW'(d);
    renDstWr = dw; renFlagRd = frd; renFlagWr = fwr;
  endtask

  task automatic cmt(input logic v, input int d, input logic dw, input logic [1:0] fw, input int p);
    cmtValid = v; cmtDst = AW'(d); cmtDstWr = dw; cmtFlagWr = fw; cmtPhys = PW'(p);
  endtask

  task automatic nextCycle();
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; flush = 1'b0;
    ren(1'b0, 0, 0, 0, 1'b0, 2'b00, 2'b00);
    cmt(1'b0, 0, 1'b0, 2'b00, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset mapping and free list head
    for (int i = 0; i < ARCH_N; i++) begin
      ren(1'b0, i, 0, 0, 1'b0, 2'b00, 2'b00);
      #1;
      chk("R1", "reset map", int'(renPhysA), i);
    end
    chk("R1", "reset carry ptr", int'(renCarryTag), ARCH_N);
    chk("R1", "reset other ptr", int'(renOtherTag), ARCH_N);
    chk("R1", "first free", int'(renNewPhys), ARCH_N + 1);
    chk("R1", "no stall", int'(renStall), 0);
    nextCycle();

    // R2 R3 R4 R5: vector walk
    for (int k = 0; k < 7; k++) begin
      ren(VEC[k].v, VEC[k].a, VEC[k].b, VEC[k].d, VEC[k].dw, VEC[k].frd, VEC[k].fwr);
      #1;
      chk("R5", $sformatf("v%0d physA", k), int'(renPhysA), int'(VEC[k].eA));
      chk("R5", $sformatf("v%0d physB", k), int'(renPhysB), int'(VEC[k].eB));
      chk("R4", $sformatf("v%0d carry tag", k), int'(renCarryTag), int'(VEC[k].eC));
      chk("R4", $sformatf("v%0d other tag", k), int'(renOtherTag), int'(VEC[k].eO));
      chk("R3", $sformatf("v%0d new phys", k), int'(renNewPhys), int'(VEC[k].eN));
      chk("R2", $sformatf("v%0d alloc", k), int'(renAlloc), int'(VEC[k].eAl));
      chk("R5", $sformatf("v%0d tag vld", k), int'(renFlagTagVld),
          int'(VEC[k].v ? VEC[k].frd : 2'b00));
      nextCycle();
    end

    // R6: drain 14 and 15, then stall
    ren(1'b1, 0, 0, 2, 1'b1, 2'b00, 2'b00); #1;
    chk("R3", "take 14", int'(renNewPhys), 14);
    nextCycle();
    ren(1'b1, 0, 0, 3, 1'b1, 2'b00, 2'b00); #1;
    chk("R3", "take 15", int'(renNewPhys), 15);
    nextCycle();
    ren(1'b1, 0, 0, 5, 1'b1, 2'b00, 2'b11); #1;
    chk("R6", "stall high", int'(renStall), 1);
    chk("R6", "no alloc when empty", int'(renAlloc), 0);
    nextCycle();
    ren(1'b1, 5, 2, 0, 1'b0, 2'b11, 2'b00); #1;
    chk("R6", "reader no stall", int'(renStall), 0);
    chk("R6", "r5 map kept", int'(renPhysA), 5);
    chk("R6", "carry kept", int'(renCarryTag), 12);
    chk("R6", "other kept", int'(renOtherTag), 12);
    chk("R5", "r2 latest", int'(renPhysB), 14);
    nextCycle();

    // R7 R8: retire v0, v1, v2
    ren(1'b0, 0, 0, 0, 1'b0, 2'b00, 2'b00);
    cmt(1'b1, 1, 1'b1, 2'b11, 9);
    nextCycle();
    cmt(1'b1, 1, 1'b1, 2'b10, 10);
    nextCycle();
    cmt(1'b1, 4, 1'b1, 2'b11, 11);
    nextCycle();
    cmt(1'b0, 0, 1'b0, 2'b00, 0);

    // R8 R10: freed 1, 8 (first commit) and 4, 9 (third); 10 still named by r1
    begin
      int expSeq [4] = '{1, 4, 8, 9};
      for (int k = 0; k < 4; k++) begin
        ren(1'b1, 0, 0, 7, 1'b1, 2'b00, 2'b00); #1;
        chk("R8", $sformatf("released reg %0d", k), int'(renNewPhys), expSeq[k]);
        chk("R8", $sformatf("alloc %0d", k), int'(renAlloc), 1);
        nextCycle();
      end
    end
    ren(1'b1, 0, 0, 7, 1'b1, 2'b00, 2'b00); #1;
    chk("R10", "committed reg 10 not free", int'(renStall), 1);
    nextCycle();

    // R9: flush with a rename in the same cycle
    flush = 1'b1;
    ren(1'b1, 0, 0, 2, 1'b1, 2'b00, 2'b11); #1;
    chk("R9", "no alloc in flush", int'(renAlloc), 0);
    chk("R9", "no stall in flush", int'(renStall), 0);
    nextCycle();
    flush = 1'b0;
    ren(1'b1, 2, 6, 3, 1'b1, 2'b11, 2'b00); #1;
    chk("R9", "r2 restored", int'(renPhysA), 2);
    chk("R9", "r6 restored", int'(renPhysB), 6);
    chk("R9", "carry restored", int'(renCarryTag), 11);
    chk("R9", "other restored", int'(renOtherTag), 11);
    chk("R9", "rebuilt head", int'(renNewPhys), 1);
    nextCycle();
    ren(1'b1, 1, 7, 0, 1'b0, 2'b00, 2'b00); #1;
    chk("R9", "r1 committed", int'(renPhysA), 10);
    chk("R9", "r7 restored", int'(renPhysB), 7);
    chk("R9", "next free after 1", int'(renNewPhys), 4);
    nextCycle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule